// File: doc/BRIEF.md
# Adaptive Coherence Cache-Side Engine

This block is the cache-side controller for a handful of cache cells, each holding one data word. Every cell is uncached, Clean or Dirty, and is tagged with one of three micro-protocols: Base, WP or Migratory. The tag changes how Commit and Reconcile instructions treat the cell. The engine looks at the instruction at the head of the processor-to-memory buffer. In the same cycle it either retires the instruction, which pops it from the buffer, or leaves it stalled, in which case the buffer holds it and offers it again.

When an instruction needs memory, the engine issues a request on a single valid/ready message port, one message per cycle. A miss sends a cache request. A Dirty Base commit sends a writeback. A Dirty WP commit sends a downgrade notice and then a writeback, in that order. Incoming messages from memory are taken in the cycle they arrive and are never stalled. There are three kinds: a fill, a downgrade request and a writeback acknowledgment.

Cells are selected directly by address: address k names cell k.

Top module: `coh_cache_engine`

## Requirements
- R1: A Loadl (op 0) or Storel (op 1) to a Clean (1) or Dirty (2) cell raises `retire_o` in the same cycle. A Loadl returns the cell word on `retire_data_o`. A Storel writes its data into the cell and leaves the cell Dirty.
- R2: A Loadl or Storel to an uncached cell keeps `retire_o` low. It issues exactly one cache request (message type 0) for that address and issues no second one while the fill is outstanding. An incoming fill (input type 0) installs the cell as Clean, with the micro-protocol named in `in_proto_i` (0 Base, 1 WP, 2 Migratory) and the word `in_data_i`, and the stalled instruction then retires.
- R3: A Commit (op 2) retires in the same cycle and issues no message when the cell is uncached, is Clean, or is Dirty under Migratory.
- R4: A Commit on a Dirty Base cell issues one writeback (message type 1) carrying the cell word and stays stalled. A writeback acknowledgment (input type 2) makes the cell Clean under Base, and the Commit then retires.
- R5: A Commit on a Dirty WP cell issues a downgrade notice (message type 2) and then a writeback (type 1) for the same address, on consecutive accepted message slots. The Commit stays stalled until the acknowledgment arrives.
- R6: A Reconcile (op 3) always retires in the same cycle. On a Clean Base cell it purges the cell to uncached. In every other case it leaves the cell unchanged.
- R7: An incoming downgrade request (input type 1) moves a cached cell from Migratory to WP, or from WP to Base. It leaves a Base cell as it is.
- R8: While `msg_valid_o` is high and `msg_ready_i` is low, the message type, address and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | Head of the processor-to-memory buffer holds an instruction |
| instr_op_i | input | 2 | 0 Loadl, 1 Storel, 2 Commit, 3 Reconcile |
| instr_addr_i | input | ADDR_W | Cell address |
| instr_data_i | input | DATA_W | Storel data |
| retire_o | output | 1 | Head instruction retires this cycle |
| retire_data_o | output | DATA_W | Loadl result |
| msg_valid_o | output | 1 | Outgoing message valid |
| msg_ready_i | input | 1 | Memory accepts the outgoing message |
| msg_type_o | output | 2 | 0 cache request, 1 writeback, 2 downgrade notice |
| msg_addr_o | output | ADDR_W | Message address |
| msg_data_o | output | DATA_W | Message data |
| in_valid_i | input | 1 | Incoming message valid, consumed at once |
| in_type_i | input | 2 | 0 fill, 1 downgrade request, 2 writeback acknowledgment |
| in_addr_i | input | ADDR_W | Incoming message address |
| in_proto_i | input | 2 | Micro-protocol for a fill |
| in_data_i | input | DATA_W | Fill data |

## Verification
The bench builds the block with four cells and 8-bit words. Four cells are enough to hold a Base cell, a WP cell and a Migratory cell side by side, plus one that is never filled, so uncached handling is always reachable. Narrow words keep the data checks easy to read. With only two address bits every cell is reached directly, so both downgrade steps and the two-message WP commit can each be driven on its own cell, with back-pressure applied to the message port.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_COMMIT = 2'd2, OP_RECON = 2'd3} op_e;
  typedef enum logic [1:0] {CST_INV = 2'd0, CST_CLEAN = 2'd1, CST_DIRTY = 2'd2} cst_e;
  typedef enum logic [1:0] {PR_BASE = 2'd0, PR_WP = 2'd1, PR_MIG = 2'd2} proto_e;
  typedef enum logic [1:0] {MSG_REQ = 2'd0, MSG_WBB = 2'd1, MSG_DOWNWB = 2'd2} msg_e;
  typedef enum logic [1:0] {IN_FILL = 2'd0, IN_DOWN = 2'd1, IN_ACK = 2'd2} in_e;

  function automatic proto_e proto_lower(proto_e p);
    case (p)
      PR_MIG:  return PR_WP;
      PR_WP:   return PR_BASE;
      default: return PR_BASE;
    endcase
  endfunction
endpackage

// File: rtl/coh_cell_array.sv
module coh_cell_array
  import coh_pkg::*;
#(
  parameter int unsigned NUM_CELLS = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] sel_i,
  input  logic              do_store_i,
  input  logic              do_purge_i,
  input  logic [DATA_W-1:0] store_data_i,
  input  logic              issue_i,
  input  msg_e              issue_type_i,
  input  logic              in_valid_i,
  input  logic [1:0]        in_type_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic [1:0]        in_proto_i,
  input  logic [DATA_W-1:0] in_data_i,
  output cst_e              st_o    [NUM_CELLS],
  output proto_e            proto_o [NUM_CELLS],
  output logic [DATA_W-1:0] data_o  [NUM_CELLS],
  output logic              pend_o  [NUM_CELLS],
  output logic              busy_o  [NUM_CELLS]
);
  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    logic hit_sel, hit_in;
    assign hit_sel = (sel_i == ADDR_W'(i));
    assign hit_in  = in_valid_i && (in_addr_i == ADDR_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_o[i]    <= CST_INV;
        proto_o[i] <= PR_BASE;
        data_o[i]  <= '0;
        pend_o[i]  <= 1'b0;
        busy_o[i]  <= 1'b0;
      end else begin
        if (hit_sel) begin
          if (do_store_i) begin
            st_o[i]   <= CST_DIRTY;
            data_o[i] <= store_data_i;
          end
          if (do_purge_i) st_o[i] <= CST_INV;
          if (issue_i && issue_type_i == MSG_REQ) pend_o[i] <= 1'b1;
          if (issue_i && issue_type_i != MSG_REQ) busy_o[i] <= 1'b1;
        end
        // incoming traffic is applied last and always consumed
        if (hit_in) begin
          case (in_type_i)
            IN_FILL: begin
              st_o[i]    <= CST_CLEAN;
              proto_o[i] <= proto_e'(in_proto_i);
              data_o[i]  <= in_data_i;
              pend_o[i]  <= 1'b0;
            end
            IN_DOWN: if (st_o[i] != CST_INV) proto_o[i] <= proto_lower(proto_o[i]);
            IN_ACK: begin
              st_o[i]    <= CST_CLEAN;
              proto_o[i] <= PR_BASE;
              busy_o[i]  <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/coh_decide.sv
module coh_decide
  import coh_pkg::*;
(
  input  logic       instr_valid_i,
  input  logic [1:0] op_i,
  input  cst_e       st_i,
  input  proto_e     proto_i,
  input  logic       pend_i,
  input  logic       busy_i,
  input  logic       can_issue_i,
  output logic       retire_o,
  output logic       do_store_o,
  output logic       do_purge_o,
  output logic       issue_o,
  output msg_e       issue_type_o,
  output logic       issue_two_o
);
  always_comb begin
    retire_o     = 1'b0;
    do_store_o   = 1'b0;
    do_purge_o   = 1'b0;
    issue_o      = 1'b0;
    issue_type_o = MSG_REQ;
    issue_two_o  = 1'b0;
    if (instr_valid_i) begin
      case (op_i)
        OP_LOAD, OP_STORE: begin
          if (st_i != CST_INV) begin
            retire_o   = 1'b1;
            do_store_o = (op_i == OP_STORE);
          end else if (!pend_i && can_issue_i) begin
            issue_o = 1'b1;
          end
        end
        OP_COMMIT: begin
          if (st_i != CST_DIRTY || proto_i == PR_MIG) begin
            retire_o = 1'b1;
          end else if (!busy_i && can_issue_i) begin
            issue_o      = 1'b1;
            issue_two_o  = (proto_i == PR_WP);
            issue_type_o = (proto_i == PR_WP) ? MSG_DOWNWB : MSG_WBB;
          end
        end
        default: begin
          retire_o   = 1'b1;
          do_purge_o = (st_i == CST_CLEAN) && (proto_i == PR_BASE);
        end
      endcase
    end
  end
endmodule

// File: rtl/coh_msg_out.sv
module coh_msg_out
  import coh_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  msg_e              issue_type_i,
  input  logic              issue_two_i,
  input  logic [ADDR_W-1:0] issue_addr_i,
  input  logic [DATA_W-1:0] issue_data_i,
  output logic              can_issue_o,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [1:0]        msg_type_o,
  output logic [ADDR_W-1:0] msg_addr_o,
  output logic [DATA_W-1:0] msg_data_o
);
  logic              slot_free;
  logic              fol_q;
  logic [ADDR_W-1:0] fol_addr_q;
  logic [DATA_W-1:0] fol_data_q;

  assign slot_free   = !msg_valid_o || msg_ready_i;
  assign can_issue_o = slot_free && !fol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_o <= 1'b0;
      msg_type_o  <= MSG_REQ;
      msg_addr_o  <= '0;
      msg_data_o  <= '0;
      fol_q       <= 1'b0;
      fol_addr_q  <= '0;
      fol_data_q  <= '0;
    end else if (slot_free) begin
      if (fol_q) begin
        // queued writeback takes the slot right after the downgrade notice
        msg_valid_o <= 1'b1;
        msg_type_o  <= MSG_WBB;
        msg_addr_o  <= fol_addr_q;
        msg_data_o  <= fol_data_q;
        fol_q       <= 1'b0;
      end else if (issue_i) begin
        msg_valid_o <= 1'b1;
        msg_type_o  <= issue_type_i;
        msg_addr_o  <= issue_addr_i;
        msg_data_o  <= issue_data_i;
        fol_q       <= issue_two_i;
        fol_addr_q  <= issue_addr_i;
        fol_data_q  <= issue_data_i;
      end else begin
        msg_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/coh_cache_engine.sv
module coh_cache_engine
  import coh_pkg::*;
#(
  parameter  int unsigned NUM_CELLS = 4,
  parameter  int unsigned DATA_W    = 8,
  localparam int unsigned ADDR_W    = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_valid_i,
  input  logic [1:0]        instr_op_i,
  input  logic [ADDR_W-1:0] instr_addr_i,
  input  logic [DATA_W-1:0] instr_data_i,
  output logic              retire_o,
  output logic [DATA_W-1:0] retire_data_o,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [1:0]        msg_type_o,
  output logic [ADDR_W-1:0] msg_addr_o,
  output logic [DATA_W-1:0] msg_data_o,
  input  logic              in_valid_i,
  input  logic [1:0]        in_type_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic [1:0]        in_proto_i,
  input  logic [DATA_W-1:0] in_data_i
);
  cst_e              st    [NUM_CELLS];
  proto_e            proto [NUM_CELLS];
  logic [DATA_W-1:0] data  [NUM_CELLS];
  logic              pend  [NUM_CELLS];
  logic              busy  [NUM_CELLS];

  cst_e   sel_st;
  proto_e sel_proto;
  logic   do_store, do_purge, issue, issue_two, can_issue;
  msg_e   issue_type;

  assign sel_st        = st[instr_addr_i];
  assign sel_proto     = proto[instr_addr_i];
  assign retire_data_o = data[instr_addr_i];

  coh_cell_array #(.NUM_CELLS(NUM_CELLS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cells (
    .clk_i, .rst_ni,
    .sel_i(instr_addr_i), .do_store_i(do_store), .do_purge_i(do_purge),
    .store_data_i(instr_data_i), .issue_i(issue), .issue_type_i(issue_type),
    .in_valid_i, .in_type_i, .in_addr_i, .in_proto_i, .in_data_i,
    .st_o(st), .proto_o(proto), .data_o(data), .pend_o(pend), .busy_o(busy)
  );

  coh_decide u_decide (
    .instr_valid_i, .op_i(instr_op_i), .st_i(sel_st), .proto_i(sel_proto),
    .pend_i(pend[instr_addr_i]), .busy_i(busy[instr_addr_i]), .can_issue_i(can_issue),
    .retire_o, .do_store_o(do_store), .do_purge_o(do_purge),
    .issue_o(issue), .issue_type_o(issue_type), .issue_two_o(issue_two)
  );

  coh_msg_out #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_msg (
    .clk_i, .rst_ni,
    .issue_i(issue), .issue_type_i(issue_type), .issue_two_i(issue_two),
    .issue_addr_i(instr_addr_i), .issue_data_i(retire_data_o),
    .can_issue_o(can_issue),
    .msg_valid_o, .msg_ready_i, .msg_type_o, .msg_addr_o, .msg_data_o
  );
endmodule

// File: rtl/coh_cache_engine_chk.sv
module coh_cache_engine_chk
  import coh_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              instr_valid_i,
  input logic [1:0]        instr_op_i,
  input logic              retire_o,
  input logic              msg_valid_o,
  input logic              msg_ready_i,
  input logic [1:0]        msg_type_o,
  input logic [ADDR_W-1:0] msg_addr_o,
  input logic [DATA_W-1:0] msg_data_o,
  input cst_e              sel_st_i,
  input proto_e            sel_proto_i
);
  assert_msg_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_type_o)
                                    && $stable(msg_addr_o) && $stable(msg_data_o));

  assert_downwb_then_wbb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_ready_i && msg_type_o == MSG_DOWNWB
    |=> msg_valid_o && msg_type_o == MSG_WBB && $stable(msg_addr_o));

  assert_no_dup_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_ready_i && msg_type_o == MSG_REQ
    |=> !(msg_valid_o && msg_type_o == MSG_REQ && msg_addr_o == $past(msg_addr_o)));

  assert_reconcile_retires_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && instr_op_i == OP_RECON |-> retire_o);

  assert_dirty_commit_stalls_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o && instr_op_i == OP_COMMIT |-> !(sel_st_i == CST_DIRTY && sel_proto_i != PR_MIG));
endmodule

bind coh_cache_engine coh_cache_engine_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .instr_valid_i, .instr_op_i, .retire_o,
  .msg_valid_o, .msg_ready_i, .msg_type_o, .msg_addr_o, .msg_data_o,
  .sel_st_i(sel_st), .sel_proto_i(sel_proto)
);

// File: tb/coh_cache_engine_test.sv
module coh_cache_engine_test;
  localparam int DW = 8;
  localparam int AW = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          instr_valid_i = 1'b0;
  logic [1:0]    instr_op_i = '0;
  logic [AW-1:0] instr_addr_i = '0;
  logic [DW-1:0] instr_data_i = '0;
  logic          retire_o;
  logic [DW-1:0] retire_data_o;
  logic          msg_valid_o;
  logic          msg_ready_i = 1'b1;
  logic [1:0]    msg_type_o;
  logic [AW-1:0] msg_addr_o;
  logic [DW-1:0] msg_data_o;
  logic          in_valid_i = 1'b0;
  logic [1:0]    in_type_i = '0;
  logic [AW-1:0] in_addr_i = '0;
  logic [1:0]    in_proto_i = '0;
  logic [DW-1:0] in_data_i = '0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  coh_cache_engine #(.NUM_CELLS(4), .DATA_W(DW)) uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic drive(logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
    instr_valid_i = 1'b1;
    instr_op_i    = op;
    instr_addr_i  = a;
    instr_data_i  = d;
    #1;
  endtask

  task automatic send_in(logic [1:0] t, logic [AW-1:0] a, logic [1:0] p, logic [DW-1:0] d);
    in_valid_i = 1'b1;
    in_type_i  = t;
    in_addr_i  = a;
    in_proto_i = p;
    in_data_i  = d;
    tick();
    in_valid_i = 1'b0;
  endtask

  // miss, single request, fill, retire
  task automatic fill_cell(logic [AW-1:0] a, logic [1:0] p, logic [DW-1:0] d);
    drive(2'd0, a, '0);
    check("R2 miss stalls", retire_o, 0);
    tick(); #1;
    check("R2 req valid", msg_valid_o, 1);
    check("R2 req type", msg_type_o, 0);
    check("R2 req addr", msg_addr_o, a);
    tick(); #1;
    check("R2 no second req", msg_valid_o, 0);
    check("R2 still stalled", retire_o, 0);
    send_in(2'd0, a, p, d); #1;
    check("R2 retire after fill", retire_o, 1);
    check("R2 fill data", retire_data_o, d);
    tick();
    instr_valid_i = 1'b0;
  endtask

  task automatic simple(string req, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d,
                        logic exp_ret);
    drive(op, a, d);
    check(req, retire_o, exp_ret);
    tick();
    instr_valid_i = 1'b0;
  endtask

  task automatic wb_commit(string req, logic [AW-1:0] a, logic [DW-1:0] d, logic wp);
    drive(2'd2, a, '0);
    check({req, " commit stalls"}, retire_o, 0);
    tick(); #1;
    check({req, " first msg valid"}, msg_valid_o, 1);
    check({req, " first msg type"}, msg_type_o, wp ? 2 : 1);
    check({req, " first msg addr"}, msg_addr_o, a);
    if (!wp) check({req, " wbb data"}, msg_data_o, d);
    tick(); #1;
    if (wp) begin
      check({req, " second msg type"}, msg_type_o, 1);
      check({req, " second msg addr"}, msg_addr_o, a);
      check({req, " second msg data"}, msg_data_o, d);
      tick(); #1;
    end
    check({req, " slot empty"}, msg_valid_o, 0);
    check({req, " stalled until ack"}, retire_o, 0);
    send_in(2'd2, a, 2'd0, '0); #1;
    check({req, " retire after ack"}, retire_o, 1);
    tick();
    instr_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R2 reset msg idle", msg_valid_o, 0);
    drive(2'd1, 2'd3, 8'hAA);
    check("R2 reset cells uncached", retire_o, 0);
    instr_valid_i = 1'b0;
  endtask

  task automatic t_hits();
    fill_cell(2'd0, 2'd0, 8'h5A);
    simple("R1 load hit clean", 2'd0, 2'd0, '0, 1);
    simple("R1 store hit", 2'd1, 2'd0, 8'h33, 1);
    drive(2'd0, 2'd0, '0);
    check("R1 load hit dirty", retire_o, 1);
    check("R1 load data after store", retire_data_o, 8'h33);
    tick();
    instr_valid_i = 1'b0;
  endtask

  task automatic t_commit_base();
    wb_commit("R4", 2'd0, 8'h33, 1'b0);
    drive(2'd3, 2'd0, '0);
    check("R4 ack left Clean Base, reconcile retires", retire_o, 1);
    tick();
    instr_valid_i = 1'b0;
    drive(2'd0, 2'd0, '0);
    check("R6 clean base purged", retire_o, 0);
    instr_valid_i = 1'b0;
  endtask

  task automatic t_commit_wp();
    fill_cell(2'd1, 2'd1, 8'h11);
    simple("R6 reconcile clean WP", 2'd3, 2'd1, '0, 1);
    simple("R6 clean WP kept", 2'd0, 2'd1, '0, 1);
    simple("R1 store WP", 2'd1, 2'd1, 8'h77, 1);
    msg_ready_i = 1'b0;
    drive(2'd2, 2'd1, '0);
    check("R5 commit stalls", retire_o, 0);
    tick(); #1;
    check("R5 downwb valid", msg_valid_o, 1);
    check("R5 downwb type", msg_type_o, 2);
    tick(); #1;
    check("R8 held valid", msg_valid_o, 1);
    check("R8 held type", msg_type_o, 2);
    check("R8 held addr", msg_addr_o, 1);
    msg_ready_i = 1'b1;
    tick(); #1;
    check("R5 wbb next", msg_type_o, 1);
    check("R5 wbb addr", msg_addr_o, 1);
    check("R5 wbb data", msg_data_o, 8'h77);
    tick(); #1;
    check("R5 slot empty", msg_valid_o, 0);
    check("R5 stalled until ack", retire_o, 0);
    send_in(2'd2, 2'd1, 2'd0, '0); #1;
    check("R5 retire after ack", retire_o, 1);
    tick();
    instr_valid_i = 1'b0;
  endtask

  task automatic t_commit_mig();
    fill_cell(2'd2, 2'd2, 8'h22);
    simple("R3 commit clean", 2'd2, 2'd2, '0, 1);
    simple("R1 store mig", 2'd1, 2'd2, 8'h44, 1);
    simple("R3 commit dirty mig", 2'd2, 2'd2, '0, 1);
    #1;
    check("R3 no message", msg_valid_o, 0);
    simple("R3 commit uncached", 2'd2, 2'd3, '0, 1);
    #1;
    check("R3 no message uncached", msg_valid_o, 0);
    simple("R6 reconcile dirty", 2'd3, 2'd2, '0, 1);
    drive(2'd0, 2'd2, '0);
    check("R6 dirty cell kept", retire_o, 1);
    check("R6 dirty data kept", retire_data_o, 8'h44);
    tick();
    instr_valid_i = 1'b0;
  endtask

  task automatic t_downgrade();
    send_in(2'd1, 2'd2, 2'd0, '0);
    wb_commit("R7 mig to WP", 2'd2, 8'h44, 1'b1);
    fill_cell(2'd0, 2'd1, 8'h66);
    simple("R1 store WP", 2'd1, 2'd0, 8'h55, 1);
    send_in(2'd1, 2'd0, 2'd0, '0);
    wb_commit("R7 WP to base", 2'd0, 8'h55, 1'b0);
    send_in(2'd1, 2'd0, 2'd0, '0);
    simple("R7 base stays, reconcile", 2'd3, 2'd0, '0, 1);
    drive(2'd0, 2'd0, '0);
    check("R7 base kept so purged", retire_o, 0);
    instr_valid_i = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #5;
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_hits();
    t_commit_base();
    t_commit_wp();
    t_commit_mig();
    t_downgrade();
    tick();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule